// File: doc/BRIEF.md
# Two-Beat Burst Splitter for a 32-bit Peripheral Port

This block takes one access request at a time from an internal requester and plays it out as AXI3-style transactions on a 32-bit peripheral port. A request gives a start address, an access size (byte, halfword or word), a word count for word accesses, and a direction. Word requests of any length become a chain of incrementing bursts. Each burst carries at most two beats, so an odd count ends in a single-beat burst. Byte and halfword accesses are always one beat, and their write strobes are taken from the low address bits.

Only one burst is ever in flight. The next address beat is issued only after the write response, or the last read beat, of the burst before it has returned. Write data arrives on a simple valid/ready source stream, one word per beat. Read data is forwarded beat by beat with no backpressure. A request that is misaligned, has an invalid size code, or asks for zero words is refused in the cycle it is presented, and nothing is put on the bus. When an accepted request finishes, a one-cycle completion pulse reports whether any burst returned an error. An error stops the request: the bursts still left are dropped.

Top module: `perif_burst_split`

## Requirements
- R1: Every address beat on either channel carries burst type INCR (AxBURST = 2'b01).
- R2: A word request for N words (size code 2'b10) produces ceil(N/2) bursts with AxSIZE = 3'b010. Each has AxLEN = 1 (two beats), except that the last has AxLEN = 0 when N is odd. AxLEN is never above 1.
- R3: The first burst address equals the request address. Each later burst address equals the previous one plus 4 times the previous burst's beat count.
- R4: Byte (size code 2'b00) and halfword (2'b01) requests are one beat, with AxSIZE 3'b000 or 3'b001. A byte write strobes only lane addr[1:0]. A halfword write strobes 4'b0011 when addr[1] = 0 and 4'b1100 when addr[1] = 1. Word beats strobe 4'b1111.
- R5: A request is refused when any of these holds: a word access with addr[1:0] != 0, a halfword access with addr[0] = 1, size code 2'b11, or a word access with a count of zero. When refused, rej_err is high in the same cycle the request is taken (req_valid and req_ready both high), no address beat follows, and no completion pulse follows.
- R6: At most one burst is outstanding. No address beat is presented until the B response, or the R beat with RLAST, of the previous burst has been accepted. No address beat is presented together with a W beat.
- R7: Each W beat consumes one source word, with wdata equal to src_data. WLAST is high exactly on the final beat of each burst.
- R8: While awvalid, arvalid or wvalid is high and its ready is low, the valid stays high and the address or data fields stay stable.
- R9: For reads, rready is high while a burst is open, and each R beat appears in the same cycle on rd_valid and rd_data.
- R10: After the final response of an accepted request, cpl_valid pulses for one cycle. cpl_err is 1 if any response was not OKAY (resp != 2'b00), and 0 otherwise. After a non-OKAY response, no further bursts of that request are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Start byte address |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 invalid |
| req_words | input | CNT_W | Word count for word requests |
| rej_err | output | 1 | Request refused this cycle |
| src_valid | input | 1 | Write data word available |
| src_ready | output | 1 | Write data word consumed |
| src_data | input | 32 | Write data word |
| rd_valid | output | 1 | Read beat forwarded |
| rd_data | output | 32 | Read beat data |
| cpl_valid | output | 1 | Request finished (one-cycle pulse) |
| cpl_err | output | 1 | A burst returned a non-OKAY response |
| awaddr | output | ADDR_W | Write address |
| awlen | output | 4 | Write burst length minus one |
| awsize | output | 3 | Write beat size |
| awburst | output | 2 | Write burst type |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| wdata | output | 32 | Write data |
| wstrb | output | 4 | Write byte strobes |
| wlast | output | 1 | Last write beat of burst |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| bresp | input | 2 | Write response |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| araddr | output | ADDR_W | Read address |
| arlen | output | 4 | Read burst length minus one |
| arsize | output | 3 | Read beat size |
| arburst | output | 2 | Read burst type |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| rdata | input | 32 | Read data |
| rresp | input | 2 | Read response |
| rlast | input | 1 | Last read beat |
| rvalid | input | 1 | Read beat valid |
| rready | output | 1 | Read beat ready |

## Verification
The W-channel stability assertion assumes the write source keeps src_valid high and src_data unchanged until src_ready takes the word, since wvalid and wdata pass straight through from the source. The assertions also assume a slave that raises B or R only for a burst it has accepted, and that sends exactly AxLEN+1 read beats with RLAST on the last. The bench slave model holds the source word fixed until its handshake, answers only bursts it has seen, and delays responses and readies at random so that each stall case is reached.

// File: rtl/perif_split_pkg.sv
package perif_split_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;

    localparam logic [1:0] BURST_INCR = 2'b01;
    localparam logic [1:0] RESP_OKAY  = 2'b00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WDAT,
        ST_WRSP,
        ST_RDAT,
        ST_DONE
    } split_state_e;

endpackage

// File: rtl/req_check.sv
module req_check
    import perif_split_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [1:0]       size,
    input  logic [1:0]       addr_lo,
    input  logic [CNT_W-1:0] words,
    output logic             ok
);
    always_comb begin
        unique case (size)
            SZ_BYTE: ok = 1'b1;
            SZ_HALF: ok = (addr_lo[0] == 1'b0);
            SZ_WORD: ok = (addr_lo == 2'b00) && (words != '0);
            default: ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/burst_calc.sv
module burst_calc
    import perif_split_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [1:0]       size,
    input  logic [CNT_W-1:0] left,
    output logic             two_beats,
    output logic [3:0]       len,
    output logic [2:0]       beat_size
);
    localparam logic [CNT_W-1:0] PAIR = CNT_W'(2);

    always_comb begin
        two_beats = (size == SZ_WORD) && (left >= PAIR);
        len       = {3'b000, two_beats};
        beat_size = {1'b0, size};
    end
endmodule

// File: rtl/lane_strobe.sv
module lane_strobe
    import perif_split_pkg::*;
(
    input  logic [1:0]       size,
    input  logic [1:0]       addr_lo,
    output logic [LANES-1:0] strb
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [1:0] LANE = 2'(i);
        always_comb begin
            unique case (size)
                SZ_WORD: strb[i] = 1'b1;
                SZ_HALF: strb[i] = (LANE[1] == addr_lo[1]);
                default: strb[i] = (LANE == addr_lo);
            endcase
        end
    end
endmodule

// File: rtl/perif_burst_split.sv
module perif_burst_split
    import perif_split_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [CNT_W-1:0]  req_words,
    output logic              rej_err,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [31:0]       src_data,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              cpl_valid,
    output logic              cpl_err,
    output logic [ADDR_W-1:0] awaddr,
    output logic [3:0]        awlen,
    output logic [2:0]        awsize,
    output logic [1:0]        awburst,
    output logic              awvalid,
    input  logic              awready,
    output logic [31:0]       wdata,
    output logic [3:0]        wstrb,
    output logic              wlast,
    output logic              wvalid,
    input  logic              wready,
    input  logic [1:0]        bresp,
    input  logic              bvalid,
    output logic              bready,
    output logic [ADDR_W-1:0] araddr,
    output logic [3:0]        arlen,
    output logic [2:0]        arsize,
    output logic [1:0]        arburst,
    output logic              arvalid,
    input  logic              arready,
    input  logic [31:0]       rdata,
    input  logic [1:0]        rresp,
    input  logic              rlast,
    input  logic              rvalid,
    output logic              rready
);
    localparam logic [ADDR_W-1:0] STEP_ONE = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] STEP_TWO = ADDR_W'(8);
    localparam logic [CNT_W-1:0]  ONE_WORD = CNT_W'(1);
    localparam logic [CNT_W-1:0]  TWO_WORD = CNT_W'(2);

    typedef struct packed {
        split_state_e      st;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  left;
        logic              beat;
        logic              wr;
        logic [1:0]        sz;
        logic              err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             req_ok;
    logic             two_beats;
    logic [3:0]       cur_len;
    logic [2:0]       cur_size;
    logic [3:0]       cur_strb;

    req_check #(.CNT_W(CNT_W)) u_check (
        .size    (req_size),
        .addr_lo (req_addr[1:0]),
        .words   (req_words),
        .ok      (req_ok)
    );

    burst_calc #(.CNT_W(CNT_W)) u_calc (
        .size      (ctl_q.sz),
        .left      (ctl_q.left),
        .two_beats (two_beats),
        .len       (cur_len),
        .beat_size (cur_size)
    );

    lane_strobe u_strobe (
        .size    (ctl_q.sz),
        .addr_lo (ctl_q.addr[1:0]),
        .strb    (cur_strb)
    );

    assign awaddr  = ctl_q.addr;
    assign araddr  = ctl_q.addr;
    assign awlen   = cur_len;
    assign arlen   = cur_len;
    assign awsize  = cur_size;
    assign arsize  = cur_size;
    assign awburst = BURST_INCR;
    assign arburst = BURST_INCR;
    assign wdata   = src_data;
    assign wstrb   = cur_strb;
    assign rd_data = rdata;

    always_comb begin
        logic resp_bad;
        logic burst_end;

        ctl_d     = ctl_q;
        req_ready = 1'b0;
        rej_err   = 1'b0;
        awvalid   = 1'b0;
        arvalid   = 1'b0;
        wvalid    = 1'b0;
        wlast     = 1'b0;
        src_ready = 1'b0;
        bready    = 1'b0;
        rready    = 1'b0;
        rd_valid  = 1'b0;
        cpl_valid = 1'b0;
        cpl_err   = 1'b0;
        resp_bad  = 1'b0;
        burst_end = 1'b0;

        unique case (ctl_q.st)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    if (!req_ok) begin
                        rej_err = 1'b1;
                    end else begin
                        ctl_d.st   = ST_ADDR;
                        ctl_d.addr = req_addr;
                        ctl_d.left = (req_size == SZ_WORD) ? req_words : ONE_WORD;
                        ctl_d.wr   = req_write;
                        ctl_d.sz   = req_size;
                        ctl_d.err  = 1'b0;
                        ctl_d.beat = 1'b0;
                    end
                end
            end
            ST_ADDR: begin
                awvalid    = ctl_q.wr;
                arvalid    = !ctl_q.wr;
                ctl_d.beat = 1'b0;
                if (ctl_q.wr && awready) begin
                    ctl_d.st = ST_WDAT;
                end else if (!ctl_q.wr && arready) begin
                    ctl_d.st = ST_RDAT;
                end
            end
            ST_WDAT: begin
                wvalid    = src_valid;
                src_ready = wready;
                wlast     = two_beats ? ctl_q.beat : 1'b1;
                if (src_valid && wready) begin
                    if (wlast) begin
                        ctl_d.st = ST_WRSP;
                    end else begin
                        ctl_d.beat = 1'b1;
                    end
                end
            end
            ST_WRSP: begin
                bready = 1'b1;
                if (bvalid) begin
                    burst_end = 1'b1;
                    resp_bad  = (bresp != RESP_OKAY);
                end
            end
            ST_RDAT: begin
                rready   = 1'b1;
                rd_valid = rvalid;
                if (rvalid) begin
                    if (rresp != RESP_OKAY) begin
                        ctl_d.err = 1'b1;
                    end
                    if (rlast) begin
                        burst_end = 1'b1;
                        resp_bad  = (rresp != RESP_OKAY);
                    end
                end
            end
            ST_DONE: begin
                cpl_valid = 1'b1;
                cpl_err   = ctl_q.err;
                ctl_d.st  = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase

        if (burst_end) begin
            if (resp_bad || ctl_q.err) begin
                ctl_d.err = 1'b1;
                ctl_d.st  = ST_DONE;
            end else if (ctl_q.left == (two_beats ? TWO_WORD : ONE_WORD)) begin
                ctl_d.st = ST_DONE;
            end else begin
                ctl_d.addr = ctl_q.addr + (two_beats ? STEP_TWO : STEP_ONE);
                ctl_d.left = ctl_q.left - (two_beats ? TWO_WORD : ONE_WORD);
                ctl_d.st   = ST_ADDR;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st   <= ST_IDLE;
            ctl_q.addr <= '0;
            ctl_q.left <= '0;
            ctl_q.beat <= 1'b0;
            ctl_q.wr   <= 1'b0;
            ctl_q.sz   <= SZ_BYTE;
            ctl_q.err  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    p_incr_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (awvalid || arvalid) |-> (awburst == BURST_INCR && arburst == BURST_INCR));

    p_len_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (awvalid || arvalid) |-> (awlen <= 4'd1 && arlen <= 4'd1));

    p_reject_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rej_err |=> (!awvalid && !arvalid && !cpl_valid));

    p_addr_apart_from_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid |-> (!wvalid && !arvalid));

    p_wlast_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wvalid && wready && wlast) |=> !wvalid);

    p_aw_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (awvalid && !awready) |=> (awvalid && $stable(awaddr) && $stable(awlen)));

    p_ar_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (arvalid && !arready) |=> (arvalid && $stable(araddr) && $stable(arlen)));

    p_w_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wvalid && !wready) |=> (wvalid && $stable(wdata) && $stable(wlast) && $stable(wstrb)));

    p_cpl_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |=> !cpl_valid);

endmodule

// File: tb/perif_burst_split_test.sv
module perif_burst_split_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_write = 0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0] req_size = 0;
    logic [CNT_W-1:0] req_words = 0;
    logic req_ready, rej_err;
    logic src_valid = 0;
    logic [31:0] src_data = 0;
    logic src_ready, rd_valid, cpl_valid, cpl_err;
    logic [31:0] rd_data;
    logic [ADDR_W-1:0] awaddr, araddr;
    logic [3:0] awlen, arlen, wstrb;
    logic [2:0] awsize, arsize;
    logic [1:0] awburst, arburst;
    logic awvalid, arvalid, wvalid, wlast, bready, rready;
    logic [31:0] wdata;
    logic awready = 0, wready = 0, bvalid = 0, arready = 0, rvalid = 0, rlast = 0;
    logic [1:0] bresp = 0, rresp = 0;
    logic [31:0] rdata = 0;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    perif_burst_split #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_words(req_words),
        .rej_err(rej_err),
        .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .cpl_valid(cpl_valid), .cpl_err(cpl_err),
        .awaddr(awaddr), .awlen(awlen), .awsize(awsize), .awburst(awburst),
        .awvalid(awvalid), .awready(awready),
        .wdata(wdata), .wstrb(wstrb), .wlast(wlast), .wvalid(wvalid), .wready(wready),
        .bresp(bresp), .bvalid(bvalid), .bready(bready),
        .araddr(araddr), .arlen(arlen), .arsize(arsize), .arburst(arburst),
        .arvalid(arvalid), .arready(arready),
        .rdata(rdata), .rresp(rresp), .rlast(rlast), .rvalid(rvalid), .rready(rready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit exp_ok(input logic [31:0] a, input logic [1:0] sz, input int words);
        case (sz)
            2'b00: return 1;
            2'b01: return a[0] == 1'b0;
            2'b10: return a[1:0] == 2'b00 && words > 0;
            default: return 0;
        endcase
    endfunction

    function automatic logic [3:0] exp_strb(input logic [1:0] sz, input logic [1:0] lo);
        case (sz)
            2'b10: return 4'b1111;
            2'b01: return lo[1] ? 4'b1100 : 4'b0011;
            default: return 4'b0001 << lo;
        endcase
    endfunction

    function automatic logic [31:0] wpat(input int i);
        return 32'hA5000000 ^ (i * 32'h00010203);
    endfunction

    function automatic logic [31:0] rpat(input int b, input int k);
        return 32'h5C000000 ^ (b << 8) ^ k;
    endfunction

    // One request from start to completion, with a randomised slave.
    task automatic do_req(input bit wr, input logic [31:0] a, input logic [1:0] sz,
                          input int words, input int err_burst);
        bit ok = exp_ok(a, sz, words);
        int left = (sz == 2'b10) ? words : 1;
        logic [31:0] exp_addr = a;
        int burst = 0, beats = 0, wbeat = 0, src_idx = 0, r_left = 0, r_beat = 0;
        int b_delay = -1, guard = 0;
        bit outstanding = 0, stop = 0, done = 0;

        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_size = sz;
        req_words = CNT_W'(words);
        #1;
        chk(req_ready == 1'b1, "R5 idle before request", {31'b0, req_ready}, 1);
        chk(rej_err == !ok, "R5 refusal flag", {31'b0, rej_err}, {31'b0, !ok});
        @(negedge clk);
        req_valid = 0;
        if (!ok) begin
            bit quiet = 1;
            for (int i = 0; i < 4; i++) begin
                #1;
                if (awvalid || arvalid || cpl_valid) quiet = 0;
                @(negedge clk);
            end
            chk(quiet, "R5 no bus activity after refusal", {31'b0, quiet}, 1);
            return;
        end
        while (!done && guard < 500) begin
            guard++;
            awready = 1'($urandom);
            arready = 1'($urandom);
            wready  = 1'($urandom);
            src_valid = 1;
            src_data = wpat(src_idx);
            bvalid = (b_delay == 0);
            bresp  = (burst == err_burst) ? 2'b10 : 2'b00;
            rvalid = (r_left > 0) && 1'($urandom);
            rlast  = (r_left == 1);
            rdata  = rpat(burst, r_beat);
            rresp  = (burst == err_burst && r_beat == 0) ? 2'b10 : 2'b00;
            #1;
            if ((awvalid && awready) || (arvalid && arready)) begin
                logic [31:0] got_a = awvalid ? awaddr : araddr;
                logic [3:0]  got_l = awvalid ? awlen : arlen;
                logic [2:0]  got_s = awvalid ? awsize : arsize;
                logic [1:0]  got_b = awvalid ? awburst : arburst;
                beats = (sz == 2'b10 && left >= 2) ? 2 : 1;
                chk(!outstanding && !stop, "R6 R10 address only when nothing pending", {31'b0, outstanding}, 0);
                chk(awvalid == wr && arvalid == !wr, "R6 channel by direction", {31'b0, awvalid}, {31'b0, wr});
                chk(got_b == 2'b01, "R1 burst type", {30'b0, got_b}, 1);
                chk(got_a == exp_addr, "R3 burst address", got_a, exp_addr);
                chk(got_l == 4'(beats - 1), "R2 burst length", {28'b0, got_l}, beats - 1);
                chk(got_s == {1'b0, sz}, "R2 R4 beat size", {29'b0, got_s}, {30'b0, sz});
                outstanding = 1;
                wbeat = 0;
                r_beat = 0;
                if (!wr) r_left = beats;
            end
            if (wvalid && wready) begin
                chk(src_ready == 1'b1, "R7 source consumed", {31'b0, src_ready}, 1);
                chk(wdata == wpat(src_idx), "R7 write data", wdata, wpat(src_idx));
                chk(wstrb == exp_strb(sz, exp_addr[1:0]), "R4 write strobes", {28'b0, wstrb},
                    {28'b0, exp_strb(sz, exp_addr[1:0])});
                chk(wlast == (wbeat == beats - 1), "R7 last beat flag", {31'b0, wlast},
                    {31'b0, wbeat == beats - 1});
                src_idx++;
                wbeat++;
                if (wlast) b_delay = 1 + int'($urandom % 3);
            end
            if (bvalid) begin
                chk(bready == 1'b1, "R6 response accepted", {31'b0, bready}, 1);
                outstanding = 0;
                if (burst == err_burst) stop = 1;
                exp_addr += 32'(4 * beats);
                left -= beats;
                burst++;
            end
            if (rvalid) begin
                chk(rready && rd_valid && rd_data == rdata, "R9 read beat forwarded", rd_data, rdata);
                r_left--;
                r_beat++;
                if (rlast) begin
                    outstanding = 0;
                    if (burst == err_burst) stop = 1;
                    exp_addr += 32'(4 * beats);
                    left -= beats;
                    burst++;
                end
            end
            if (cpl_valid) begin
                chk(left == 0 || stop, "R10 completion after final burst", left, 0);
                chk(cpl_err == stop, "R10 completion error flag", {31'b0, cpl_err}, {31'b0, stop});
                done = 1;
            end
            if (bvalid) b_delay = -1;
            else if (b_delay > 0) b_delay--;
            @(negedge clk);
            bvalid = 0; rvalid = 0;
        end
        chk(done, "R10 request completed", {31'b0, done}, 1);
        #1;
        chk(cpl_valid == 1'b0, "R10 single-cycle pulse", {31'b0, cpl_valid}, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        #1;
        chk(req_ready && !awvalid && !arvalid && !wvalid && !cpl_valid, "R6 R10 reset state",
            {27'b0, req_ready, awvalid, arvalid, wvalid, cpl_valid}, 32'h10);
        rst_n = 1;
        // directed corners
        do_req(1, 32'h00, 2'b10, 8, -1);  // four two-beat bursts, R2 R3
        do_req(1, 32'h00, 2'b10, 3, -1);  // odd tail, R2
        do_req(0, 32'h40, 2'b10, 5, -1);  // read chain, R9
        do_req(1, 32'h00, 2'b01, 1, -1);  // halfword low, R4
        do_req(1, 32'h06, 2'b01, 1, -1);  // halfword high, R4
        do_req(1, 32'h0B, 2'b00, 1, -1);  // byte lane 3, R4
        do_req(1, 32'h02, 2'b10, 2, -1);  // misaligned word, R5
        do_req(0, 32'h05, 2'b01, 1, -1);  // misaligned half, R5
        do_req(1, 32'h10, 2'b10, 0, -1);  // zero count, R5
        do_req(1, 32'h10, 2'b11, 1, -1);  // invalid size, R5
        do_req(1, 32'h20, 2'b10, 7, 1);   // write error, R10
        do_req(0, 32'h80, 2'b10, 6, 0);   // read error, R10
        // constrained random
        for (int t = 0; t < 60; t++) begin
            logic [1:0] sz = 2'($urandom % 4);
            logic [31:0] a = {$urandom % 32'h1000};
            int words = int'($urandom % 10);
            int eb = ($urandom % 5 == 0) ? int'($urandom % 3) : -1;
            if ($urandom % 4 != 0) begin
                if (sz == 2'b10) a[1:0] = 2'b00;
                if (sz == 2'b01) a[0] = 1'b0;
                if (sz == 2'b11) sz = 2'b10;
                if (sz == 2'b10) begin
                    a[1:0] = 2'b00;
                    if (words == 0) words = 1;
                end
            end
            do_req(1'($urandom), a, sz, words, eb);
        end
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule